// File: doc/BRIEF.md
# Gated Elapsed Time Counter

This block keeps a 44-bit binary count of elapsed time: 12 fractional-second bits under 32 whole-second bits. The count advances by one on each update tick, at 4096 Hz or about 244 µs per step. The update tick is derived inside the block from a faster reference tick enable (`fastTick`) by dividing by `DIV`. A 2-bit mode field selects when the count may advance: always, while an external event input is at its active level, only while running on primary power, or only while running on backup power.

Software does not read the live counter. It reads a 48-bit user copy. That copy is refreshed from the counter on every update tick while the transfer-enable input is 1, and it is frozen while transfer-enable is 0. An update-in-progress flag (`uip`) rises a fixed number of reference ticks before each update and falls in the same cycle that the update takes place. The host can therefore start an access as soon as it sees the flag low.

To set the counter, the host clears transfer-enable, writes bytes of the user copy, and then sets transfer-enable again. The 0-to-1 edge of transfer-enable loads the user copy into the counter. While power fail is indicated, host writes and the load are both dropped.

Top module: `elapsed_timer`

## Requirements
- R1: After reset, `userCopy` is all zero and `uip` is 0.
- R2: Every `DIV`-th `fastTick` is an update tick. On an update tick with counting allowed, the 44-bit counter, laid out as {seconds[31:0], subseconds[11:0]}, rises by exactly one.
- R3: With `cfgMode` = 01, counting is allowed only while `extIn` equals `extPol` and `powerFail` is 0. While `powerFail` is 1 the level of `extIn` has no effect.
- R4: With `cfgMode` = 00, counting is always allowed. With 10, it is allowed only while `onBackup` is 0. With 11, it is allowed only while `onBackup` is 1.
- R5: On an update tick with `xferEn` = 1, `userCopy` takes the counter value after that tick. While `xferEn` = 0, only host writes change `userCopy`.
- R6: `uip` is 1 during the last `LEAD` reference-tick periods before each update and drops in the cycle of the update. `userCopy` never changes in a cycle that follows one with `uip` = 0, unless the change comes from a host write.
- R7: `userCopy` layout: bits 47:16 hold seconds 31:0 (byte 2 is the least significant seconds byte). Bits 15:4 hold subseconds 11:0. Bits 3:1 are always zero. Bit 0 is a square-wave sync bit that only the host writes and that refreshes leave unchanged.
- R8: A write with `wrEn` = 1 replaces byte `wrAddr` (0 to 5) of `userCopy` with `wrData`; in byte 0, bits 3:1 are forced to 0. Addresses 6 and 7 change nothing. If a write and a refresh fall in the same cycle, the write wins.
- R9: In the cycle after a 0-to-1 edge of `xferEn`, the counter holds the seconds and subseconds fields of `userCopy`. A load takes priority over an increment in the same cycle.
- R10: While `powerFail` = 1, host writes and transfer-enable loads are ignored.
- R11: The counter wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastTick | input | 1 | Reference tick enable, `DIV` per update |
| powerFail | input | 1 | Primary supply below threshold |
| onBackup | input | 1 | Block is running from backup supply |
| extIn | input | 1 | External event input |
| cfgMode | input | 2 | Count mode select |
| extPol | input | 1 | Active level of `extIn` in event mode |
| xferEn | input | 1 | Transfer enable for the user copy |
| wrEn | input | 1 | Host byte write strobe |
| wrAddr | input | 3 | Byte index of the user copy |
| wrData | input | 8 | Host write data |
| userCopy | output | 48 | Buffered counter image |
| uip | output | 1 | Update-in-progress flag |

## Verification
The bench builds the block with its defaults, `DIV` = 8 and `LEAD` = 2. With these values an update comes every eight reference ticks, so hundreds of updates fit in a short run, with every mode transition, load and refresh collision among them. The reference tick is driven both continuously and in sparse patterns, which moves the update cycle against host writes and edges of `xferEn`. The 44-bit wrap is reached by loading all ones through the host bytes and not by counting up to it.

// File: rtl/elapsed_timer_pkg.sv
package elapsed_timer_pkg;
  localparam int SUB_W  = 12;
  localparam int SEC_W  = 32;
  localparam int CNT_W  = SUB_W + SEC_W;
  localparam int COPY_W = CNT_W + 4;
  localparam int NBYTES = COPY_W / 8;

  typedef struct packed {
    logic load;     // copy -> counter
    logic inc;      // counter + 1
    logic refresh;  // counter -> copy
    logic hostWr;   // accepted byte write
  } strobeT;
endpackage

// File: rtl/elapsed_timer_ctrl.sv
module elapsed_timer_ctrl
  import elapsed_timer_pkg::*;
#(
  parameter int DIV  = 8,
  parameter int LEAD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fastTick,
  input  logic       powerFail,
  input  logic       onBackup,
  input  logic       extIn,
  input  logic [1:0] cfgMode,
  input  logic       extPol,
  input  logic       xferEn,
  input  logic       wrEn,
  output strobeT     strb,
  output logic       uip
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_UIP  = PH_W'(DIV - LEAD);

  logic [PH_W-1:0] phase;
  logic            xferPrev;
  logic            update;
  logic            gate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= '0;
      xferPrev <= 1'b0;
    end else begin
      xferPrev <= xferEn;
      if (fastTick) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  assign update = fastTick && (phase == PH_LAST);
  assign uip    = (phase >= PH_UIP);

  always_comb begin
    unique case (cfgMode)
      2'b00:   gate = 1'b1;
      2'b01:   gate = !powerFail && (extIn == extPol);
      2'b10:   gate = !onBackup;
      default: gate = onBackup;
    endcase
  end

  always_comb begin
    strb.load    = xferEn && !xferPrev && !powerFail;
    strb.inc     = update && gate;
    strb.refresh = update && xferEn;
    strb.hostWr  = wrEn && !powerFail;
  end

  AST_UIP_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    update |=> !uip) else $error("uip after update"); // R6
  AST_EVENT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b01 && powerFail) |-> !strb.inc) else $error("count in fail"); // R3
  AST_NO_FAIL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |-> !strb.hostWr && !strb.load) else $error("write in fail"); // R10
endmodule

// File: rtl/elapsed_timer_dp.sv
module elapsed_timer_dp
  import elapsed_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [2:0]        wrAddr,
  input  logic [7:0]        wrData,
  output logic [COPY_W-1:0] copyQ
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] loadVal;

  assign loadVal = {copyQ[COPY_W-1:16], copyQ[15:4]};

  always_comb begin
    if (strb.load)     cntNext = loadVal;
    else if (strb.inc) cntNext = cnt + 1'b1;
    else               cntNext = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cntNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      copyQ <= '0;
    end else if (strb.hostWr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wrAddr == 3'(b)) begin
          if (b == 0) copyQ[7:0] <= {wrData[7:4], 3'b000 & wrData[3:1], wrData[0]};
          else        copyQ[8*b +: 8] <= wrData;
        end
      end
    end else if (strb.refresh) begin
      copyQ <= {cntNext, 3'b000, copyQ[0]};
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.load) |=> cnt == $past(cnt) + 1'b1) else $error("step"); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.load && cnt == '1) |=> cnt == '0) else $error("wrap"); // R11
  AST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> cnt == {$past(copyQ[COPY_W-1:16]), $past(copyQ[15:4])}) else $error("load"); // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.refresh && !strb.hostWr) |=> $stable(copyQ)) else $error("frozen"); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    copyQ[3:1] == 3'b000) else $error("reserved"); // R7
endmodule

// File: rtl/elapsed_timer.sv
module elapsed_timer
  import elapsed_timer_pkg::*;
#(
  parameter int DIV  = 8,
  parameter int LEAD = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fastTick,
  input  logic        powerFail,
  input  logic        onBackup,
  input  logic        extIn,
  input  logic [1:0]  cfgMode,
  input  logic        extPol,
  input  logic        xferEn,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  output logic [47:0] userCopy,
  output logic        uip
);
  strobeT strb;

  elapsed_timer_ctrl #(.DIV(DIV), .LEAD(LEAD)) uCtrl (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .powerFail(powerFail),
    .onBackup(onBackup), .extIn(extIn), .cfgMode(cfgMode), .extPol(extPol),
    .xferEn(xferEn), .wrEn(wrEn), .strb(strb), .uip(uip)
  );

  elapsed_timer_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr),
    .wrData(wrData), .copyQ(userCopy)
  );

  AST_COPY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (userCopy != $past(userCopy)) && !$past(strb.hostWr) |-> $past(uip))
    else $error("copy moved outside window"); // R6
endmodule

// File: tb/sim_elapsed_timer.sv
`timescale 1ns/1ps
module sim_elapsed_timer;
  localparam int DIV = 8;
  localparam int LEAD = 2;

  logic clk = 0, rstN = 0, fastTick = 0, powerFail = 0, onBackup = 0, extIn = 0;
  logic [1:0] cfgMode = 0;
  logic extPol = 0, xferEn = 0, wrEn = 0;
  logic [2:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic [47:0] userCopy;
  logic uip;

  int checks = 0, errors = 0;
  string curReq = "R1";
  bit done = 0;

  elapsed_timer #(.DIV(DIV), .LEAD(LEAD)) u0 (.*);

  always #4 clk = ~clk;

  // behavioural reference
  logic [43:0] mCnt;
  logic [47:0] mCopy;
  int mPhase;
  bit mXPrev, mUpd, mWr;
  always @(posedge clk) begin : model
    bit ok, ld;
    logic [43:0] nxt;
    if (!rstN) begin
      mCnt = 0; mCopy = 0; mPhase = 0; mXPrev = 0; mUpd = 0; mWr = 0;
    end else begin
      mUpd = fastTick && (mPhase == DIV - 1);
      case (cfgMode)
        2'd0: ok = 1;
        2'd1: ok = !powerFail && (extIn == extPol);
        2'd2: ok = !onBackup;
        default: ok = onBackup;
      endcase
      ld = xferEn && !mXPrev && !powerFail;
      nxt = ld ? {mCopy[47:16], mCopy[15:4]} : (mUpd && ok) ? mCnt + 44'd1 : mCnt;
      mWr = wrEn && !powerFail;
      if (mWr) begin
        if (wrAddr == 0) mCopy[7:0] = {wrData[7:4], 3'b000, wrData[0]};
        else if (wrAddr < 6) mCopy[8*wrAddr +: 8] = wrData;
      end else if (mUpd && xferEn) mCopy = {nxt, 3'b000, mCopy[0]};
      mCnt = nxt;
      mXPrev = xferEn;
      if (fastTick) mPhase = (mPhase == DIV - 1) ? 0 : mPhase + 1;
    end
  end

  task automatic chk(bit cond, string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [47:0] copyPrev = 0;
  bit uipPrev = 0;
  task automatic cyc();
    @(posedge clk); #1;
    if (rstN) begin
      chk(userCopy === mCopy, curReq, userCopy, mCopy);
      chk(uip === (mPhase >= DIV - LEAD), "R6", 48'(uip), 48'(mPhase >= DIV - LEAD));
      if (userCopy !== copyPrev && !mWr)
        chk(uipPrev, "R6", 48'(uipPrev), 48'd1);
    end
    copyPrev = userCopy; uipPrev = uip;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, logic [7:0] d);
    wrEn = 1; wrAddr = 3'(a); wrData = d; cyc(); wrEn = 0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run(3);
    rstN = 1; #1;
    chk(userCopy === 48'd0, "R1", userCopy, 0);
    chk(uip === 1'b0, "R1", 48'(uip), 0);
    fastTick = 1;
    // R2 R5 R7: free-running, transfer on
    curReq = "R2"; xferEn = 1; run(60);
    chk(userCopy[15:4] == 12'd7 || userCopy[15:4] == 12'd8, "R7", userCopy, 48'd7 << 4);
    // R5: frozen copy
    curReq = "R5"; xferEn = 0; run(40);
    // R8: host byte writes, invalid addresses ignored
    curReq = "R8";
    wr(0, 8'hAF); wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'h56); wr(4, 8'h78); wr(5, 8'h9A);
    wr(6, 8'hFF); wr(7, 8'hFF);
    chk(userCopy === 48'h9A78_5634_12A1, "R8", userCopy, 48'h9A78_5634_12A1);
    // R9: load on rising transfer enable
    curReq = "R9"; xferEn = 1; run(DIV + 2);
    chk(userCopy[47:4] == 44'h9A78_5634_12A + 1, "R9", userCopy, {44'h9A78_5634_12B, 4'h1});
    // R11: wrap
    curReq = "R11"; xferEn = 0; cyc();
    for (int b = 0; b < 6; b++) wr(b, 8'hFF);
    xferEn = 1; cyc();
    while (!mUpd) cyc();
    chk(userCopy[47:4] == 44'd0, "R11", userCopy, 48'h1);
    // R3: event mode, both polarities
    curReq = "R3"; cfgMode = 2'b01;
    for (int p = 0; p < 2; p++) begin
      extPol = p[0];
      for (int i = 0; i < 50; i++) begin extIn = (i / 7) % 2 == 1; cyc(); end
    end
    // R10: power fail blocks event counting, writes and loads
    curReq = "R10"; powerFail = 1; extIn = extPol; run(20);
    xferEn = 0; cyc(); wr(2, 8'h55); xferEn = 1; run(2 * DIV);
    powerFail = 0; run(10);
    // R4: power-source modes
    curReq = "R4";
    for (int m = 2; m < 4; m++) begin
      cfgMode = 2'(m);
      for (int i = 0; i < 60; i++) begin onBackup = (i / 11) % 2 == 1; cyc(); end
    end
    // R9: load/increment collisions with sparse reference ticks
    curReq = "R9"; cfgMode = 0;
    for (int i = 0; i < 300; i++) begin
      fastTick = (i % 3) != 1;
      xferEn = (i % 13) < 8;
      if (i % 17 == 5) begin wrEn = 1; wrAddr = 3'(i % 8); wrData = 8'(i * 37); end
      else wrEn = 0;
      cyc();
    end
    wrEn = 0; run(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule